// File: doc/BRIEF.md
# Interrupt Pin Request Tracker

This block keeps one request bit per interrupt pin and decides when each pin needs service. Each entry has a polarity bit, a trigger mode (edge or level), a mask bit and a vector. A level entry also keeps an in-service flag (remote IRR). The block issues deliveries one at a time over a valid/ready handshake. Each delivery carries the index of the entry being serviced. Resolving which destination receives a delivery is left to the logic downstream.

End-of-interrupt messages carry a vector. The tracker searches the entry table for that vector and clears the in-service flag of the matching level entry. If that entry is unmasked and its request is still active, it is then delivered again. The register window that owns the entry table reports every write to the low half of an entry. Such a write also clears that entry's in-service flag, so a level request that is still asserted is serviced again.

Top module: `irq_req_tracker`

## Requirements
- R1: After reset, all request bits, in-service flags and the error flag are 0, and `dlv_valid` is 0.
- R2: The effective level of a pin is `pin_in` XOR `cfg_pol`, so `cfg_pol`=1 makes the pin active-low.
- R3: For a level entry (`cfg_trig`=1), the request bit on `pend_o` equals the effective level one clock later. An effective level of 0 clears the bit.
- R4: For an edge entry (`cfg_trig`=0), a 0-to-1 change of the effective level sets the request bit. The bit is cleared by an effective level of 0, by the entry being masked, or by the clock edge on which its delivery is accepted. Once cleared, it stays 0 until the next rising edge of the effective level.
- R5: An entry is eligible when it is unmasked, its request bit is set and, for a level entry, its in-service flag is 0. `dlv_valid` is 1 when any entry is eligible, and `dlv_idx` names the lowest-index eligible entry. Exactly one delivery is accepted on each clock edge where `dlv_valid` and `dlv_ready` are both 1.
- R6: When a delivery of a level entry is accepted, that entry's in-service flag on `rirr_o` goes to 1 on the same edge. The entry is then not delivered again while the flag stays set. If a clear and an acceptance hit the same entry on the same edge, the set takes effect.
- R7: An entry with `cfg_mask`=1 is never delivered. A masked level entry does not set its in-service flag.
- R8: With `eoi_valid`=1, the lowest-index entry whose `cfg_vec` field equals `eoi_vec` is selected. If that entry is level-triggered, its in-service flag clears on the next edge. If it is also unmasked and its request bit is still set, it becomes eligible again.
- R9: An end-of-interrupt whose vector matches no entry changes no state, and `eoi_err` stays 0.
- R10: An end-of-interrupt whose selected entry is edge-triggered raises `eoi_err` for one cycle after that edge and changes no in-service flag.
- R11: `win_wr`=1 with `win_low`=1 clears the in-service flag of entry `win_idx`. A write with `win_low`=0, or with `win_idx` not below the entry count, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | N_PINS | Raw pin levels |
| cfg_pol | input | N_PINS | Polarity per entry, 1 = active-low |
| cfg_trig | input | N_PINS | Trigger mode per entry, 1 = level, 0 = edge |
| cfg_mask | input | N_PINS | Mask per entry, 1 = masked |
| cfg_vec | input | N_PINS*VEC_W | Vector of entry i in bits [i*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | End-of-interrupt message present |
| eoi_vec | input | VEC_W | Vector carried by the end-of-interrupt |
| win_wr | input | 1 | Register window wrote an entry |
| win_idx | input | WIN_W | Entry index of that write |
| win_low | input | 1 | The write targeted the low half of the entry |
| dlv_ready | input | 1 | Downstream accepts a delivery |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_idx | output | $clog2(N_PINS) | Entry index of the offered delivery |
| pend_o | output | N_PINS | Request bits |
| rirr_o | output | N_PINS | In-service flags |
| eoi_err | output | 1 | End-of-interrupt matched an edge entry |

## Verification
A corrupted request bit or in-service flag shows up on `pend_o` and `rirr_o` on the next clock. It then shows up on `dlv_valid` and `dlv_idx` in the same cycle, as a missing, extra or repeated delivery. A wrong table search on end-of-interrupt clears the flag of the wrong entry. That entry is redelivered at once if its pin is still active, and `eoi_err` rises or stays low one cycle after the message. The bench runs a model of every entry alongside the design and compares all outputs every cycle. Each divergence is therefore caught in the cycle it first appears at the ports.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;
    localparam int DEF_PINS  = 8;
    localparam int DEF_VEC_W = 8;
    localparam int DEF_WIN_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pin_cond.sv
module pin_cond #(
    parameter int N = 8
) (
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] prev,
    output logic [N-1:0] eff,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        assign eff[g]  = pin[g] ^ pol[g];
        assign rise[g] = eff[g] & ~prev[g];
    end
endmodule

// File: rtl/vec_match.sv
module vec_match #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input  logic [N*VEC_W-1:0] table_vec,
    input  logic [VEC_W-1:0]   key,
    output logic [N-1:0]       hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (table_vec[g*VEC_W +: VEC_W] == key);
    end
endmodule

// File: rtl/irq_req_tracker.sv
module irq_req_tracker
    import irq_track_pkg::*;
#(
    parameter int N_PINS = DEF_PINS,
    parameter int VEC_W  = DEF_VEC_W,
    parameter int WIN_W  = DEF_WIN_W,
    localparam int IW    = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PINS-1:0]       pin_in,
    input  logic [N_PINS-1:0]       cfg_pol,
    input  logic [N_PINS-1:0]       cfg_trig,
    input  logic [N_PINS-1:0]       cfg_mask,
    input  logic [N_PINS*VEC_W-1:0] cfg_vec,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vec,
    input  logic                    win_wr,
    input  logic [WIN_W-1:0]        win_idx,
    input  logic                    win_low,
    input  logic                    dlv_ready,
    output logic                    dlv_valid,
    output logic [IW-1:0]           dlv_idx,
    output logic [N_PINS-1:0]       pend_o,
    output logic [N_PINS-1:0]       rirr_o,
    output logic                    eoi_err
);
    localparam logic [N_PINS-1:0] ONE = {{(N_PINS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [N_PINS-1:0] pend;
        logic [N_PINS-1:0] rirr;
        logic [N_PINS-1:0] prev;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic [N_PINS-1:0] eff, rise, want, cand, hit;
    logic [N_PINS-1:0] gnt, eoi_clr, win_clr;
    logic              eoi_found;
    logic [IW-1:0]     eoi_idx;
    logic              win_in_range;

    pin_cond #(.N(N_PINS)) i_pin_cond (
        .pin  (pin_in),
        .pol  (cfg_pol),
        .prev (st_q.prev),
        .eff  (eff),
        .rise (rise)
    );

    vec_match #(.N(N_PINS), .VEC_W(VEC_W)) i_vec_match (
        .table_vec (cfg_vec),
        .key       (eoi_vec),
        .hit       (hit)
    );

    lowest_pick #(.N(N_PINS)) i_eoi_pick (
        .req   (hit),
        .found (eoi_found),
        .idx   (eoi_idx)
    );

    // Level entries wait for their in-service flag; edge entries do not.
    always_comb begin
        for (int i = 0; i < N_PINS; i++) begin
            want[i] = st_q.pend[i] & (cfg_trig[i] == TRIG_EDGE || !st_q.rirr[i]);
        end
        cand = want & ~cfg_mask;
    end

    lowest_pick #(.N(N_PINS)) i_dlv_pick (
        .req   (cand),
        .found (dlv_valid),
        .idx   (dlv_idx)
    );

    assign win_in_range = (int'(win_idx) < N_PINS);

    always_comb begin
        gnt     = (dlv_valid && dlv_ready) ? (ONE << dlv_idx) : '0;
        eoi_clr = (eoi_valid && eoi_found && cfg_trig[eoi_idx] == TRIG_LEVEL)
                  ? (ONE << eoi_idx) : '0;
        win_clr = (win_wr && win_low && win_in_range)
                  ? (ONE << win_idx[IW-1:0]) : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_PINS; i++) begin
            if (cfg_trig[i] == TRIG_LEVEL) begin
                st_d.pend[i] = eff[i];
            end else begin
                st_d.pend[i] = eff[i] & (st_q.pend[i] | rise[i]) & ~cfg_mask[i] & ~gnt[i];
            end
            if (eoi_clr[i] || win_clr[i]) begin
                st_d.rirr[i] = 1'b0;
            end
            if (gnt[i] && cfg_trig[i] == TRIG_LEVEL) begin
                st_d.rirr[i] = 1'b1;
            end
        end
        st_d.prev = eff;
        st_d.err  = eoi_valid && eoi_found && (cfg_trig[eoi_idx] == TRIG_EDGE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign rirr_o  = st_q.rirr;
    assign eoi_err = st_q.err;
endmodule

// File: rtl/irq_req_tracker_chk.sv
module irq_req_tracker_chk #(
    parameter int N_PINS = 8,
    parameter int VEC_W  = 8,
    parameter int WIN_W  = 8,
    localparam int IW    = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] cfg_trig,
    input logic [N_PINS-1:0] cfg_mask,
    input logic              eoi_valid,
    input logic              dlv_ready,
    input logic              dlv_valid,
    input logic [IW-1:0]     dlv_idx,
    input logic [N_PINS-1:0] pend_o,
    input logic [N_PINS-1:0] rirr_o,
    input logic              eoi_err
);
    // R7: a masked entry is never offered
    a_r7_masked_never_offered: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !cfg_mask[dlv_idx]);

    // R5: an offered entry has its request bit set
    a_r5_offer_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> pend_o[dlv_idx]);

    // R6: a level entry is not offered while in service
    a_r6_no_offer_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && cfg_trig[dlv_idx]) |-> !rirr_o[dlv_idx]);

    // R6: accepted level delivery sets the in-service flag
    a_r6_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && cfg_trig[dlv_idx]) |=> rirr_o[$past(dlv_idx)]);

    // R4: accepted edge delivery clears the request bit
    a_r4_accept_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && !cfg_trig[dlv_idx]) |=> !pend_o[$past(dlv_idx)]);

    // R10: the error flag follows an end-of-interrupt only
    a_r10_err_needs_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_valid |=> !eoi_err);
endmodule

bind irq_req_tracker irq_req_tracker_chk #(
    .N_PINS (N_PINS),
    .VEC_W  (VEC_W),
    .WIN_W  (WIN_W)
) i_irq_req_tracker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_trig  (cfg_trig),
    .cfg_mask  (cfg_mask),
    .eoi_valid (eoi_valid),
    .dlv_ready (dlv_ready),
    .dlv_valid (dlv_valid),
    .dlv_idx   (dlv_idx),
    .pend_o    (pend_o),
    .rirr_o    (rirr_o),
    .eoi_err   (eoi_err)
);

// File: tb/test_irq_req_tracker.sv
`timescale 1ns/100ps
module test_irq_req_tracker;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0, cfg_pol = '0, cfg_trig = '1, cfg_mask = '1;
    logic [N*VW-1:0] cfg_vec = '0;
    logic          eoi_valid = 1'b0;
    logic [VW-1:0] eoi_vec = '0;
    logic          win_wr = 1'b0, win_low = 1'b0, dlv_ready = 1'b0;
    logic [WW-1:0] win_idx = '0;
    logic          dlv_valid, eoi_err;
    logic [2:0]    dlv_idx;
    logic [N-1:0]  pend_o, rirr_o;

    int n_chk = 0;
    int n_err = 0;
    logic [N-1:0] m_pend = '0, m_rirr = '0, m_prev = '0;
    logic         m_err = 1'b0;

    always #2.5 clk = ~clk;

    irq_req_tracker i_irq_req_tracker (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_pol(cfg_pol),
        .cfg_trig(cfg_trig), .cfg_mask(cfg_mask), .cfg_vec(cfg_vec),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .win_wr(win_wr),
        .win_idx(win_idx), .win_low(win_low), .dlv_ready(dlv_ready),
        .dlv_valid(dlv_valid), .dlv_idx(dlv_idx), .pend_o(pend_o),
        .rirr_o(rirr_o), .eoi_err(eoi_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge with inputs applied: compare, advance model, wait one clock.
    task automatic tick();
        logic [N-1:0] cand, eff, rise, gnt, nxt_pend, nxt_rirr;
        logic         e_valid, found;
        int           e_idx, m_idx;
        #1;
        cand = '0;
        for (int i = 0; i < N; i++)
            cand[i] = m_pend[i] && !cfg_mask[i] && (!cfg_trig[i] || !m_rirr[i]);
        e_valid = |cand;
        e_idx = 0;
        for (int i = N - 1; i >= 0; i--) if (cand[i]) e_idx = i;
        chk(pend_o == m_pend, "R3 R4 request bits", 32'(pend_o), 32'(m_pend));
        chk(rirr_o == m_rirr, "R6 R8 R11 in-service flags", 32'(rirr_o), 32'(m_rirr));
        chk(eoi_err == m_err, "R10 error flag", 32'(eoi_err), 32'(m_err));
        chk(dlv_valid == e_valid, "R5 R7 dlv_valid", 32'(dlv_valid), 32'(e_valid));
        if (e_valid) chk(int'(dlv_idx) == e_idx, "R5 dlv_idx lowest", 32'(dlv_idx), 32'(e_idx));
        eff  = pin_in ^ cfg_pol;
        rise = eff & ~m_prev;
        gnt  = (e_valid && dlv_ready) ? (N'(1) << e_idx) : '0;
        found = 1'b0;
        m_idx = 0;
        for (int i = N - 1; i >= 0; i--)
            if (cfg_vec[i*VW +: VW] == eoi_vec) begin found = 1'b1; m_idx = i; end
        nxt_rirr = m_rirr;
        for (int i = 0; i < N; i++) begin
            nxt_pend[i] = cfg_trig[i] ? eff[i]
                        : (eff[i] & (m_pend[i] | rise[i]) & ~cfg_mask[i] & ~gnt[i]);
            if (eoi_valid && found && m_idx == i && cfg_trig[i]) nxt_rirr[i] = 1'b0;
            if (win_wr && win_low && int'(win_idx) == i) nxt_rirr[i] = 1'b0;
            if (gnt[i] && cfg_trig[i]) nxt_rirr[i] = 1'b1;
        end
        m_err  = eoi_valid && found && !cfg_trig[m_idx];
        m_pend = nxt_pend;
        m_rirr = nxt_rirr;
        m_prev = eff;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(pend_o == 0 && rirr_o == 0, "R1 reset state", 32'({pend_o, rirr_o}), 32'h0);
        chk(!dlv_valid && !eoi_err, "R1 reset outputs", 32'({dlv_valid, eoi_err}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        tick();

        // R2: active-low level pin 0, still masked
        cfg_pol[0] = 1'b1;
        tick();
        chk(pend_o[0] == 1'b1, "R2 active-low request", 32'(pend_o[0]), 32'h1);
        chk(!dlv_valid && !rirr_o[0], "R7 masked not offered", 32'({dlv_valid, rirr_o[0]}), 32'h0);

        // R5 R6: unmask, offer, accept
        cfg_mask[0] = 1'b0;
        cfg_vec[0 +: VW] = 8'h21;
        cfg_vec[3*VW +: VW] = 8'h21;
        tick();
        chk(dlv_valid && dlv_idx == 0, "R5 offer entry 0", 32'({dlv_valid, dlv_idx}), 32'h8);
        dlv_ready = 1'b1;
        tick();
        dlv_ready = 1'b0;
        chk(rirr_o[0] && !dlv_valid, "R6 in service after accept", 32'({rirr_o[0], dlv_valid}), 32'h2);

        // R8: EOI selects lowest match and re-arms
        eoi_valid = 1'b1; eoi_vec = 8'h21;
        tick();
        eoi_valid = 1'b0;
        chk(!rirr_o[0] && dlv_valid && dlv_idx == 0, "R8 redeliver after eoi",
            32'({rirr_o[0], dlv_valid}), 32'h1);
        dlv_ready = 1'b1;
        tick();
        dlv_ready = 1'b0;

        // R9: unmatched EOI
        eoi_valid = 1'b1; eoi_vec = 8'h99;
        tick();
        eoi_valid = 1'b0;
        chk(rirr_o[0] && !eoi_err, "R9 unmatched eoi ignored", 32'({rirr_o[0], eoi_err}), 32'h2);

        // R10: EOI matching edge entry 1
        cfg_trig[1] = 1'b0; cfg_mask[1] = 1'b0; cfg_vec[VW +: VW] = 8'h40;
        eoi_valid = 1'b1; eoi_vec = 8'h40;
        tick();
        eoi_valid = 1'b0;
        chk(eoi_err && rirr_o[0], "R10 edge eoi error", 32'({eoi_err, rirr_o[0]}), 32'h3);
        tick();
        chk(!eoi_err, "R10 error is one cycle", 32'(eoi_err), 32'h0);

        // R4: edge entry 2 rises, accepted, stays clear while pin high
        cfg_trig[2] = 1'b0; cfg_mask[2] = 1'b0; pin_in[2] = 1'b1;
        tick();
        chk(pend_o[2] && dlv_valid && dlv_idx == 2, "R4 edge request", 32'({pend_o[2], dlv_idx}), 32'hA);
        dlv_ready = 1'b1;
        tick();
        dlv_ready = 1'b0;
        tick();
        chk(!pend_o[2] && !dlv_valid, "R4 cleared after accept", 32'({pend_o[2], dlv_valid}), 32'h0);

        // R11: high-half and out-of-range writes ignored, low-half clears
        win_wr = 1'b1; win_low = 1'b0; win_idx = 0;
        tick();
        chk(rirr_o[0], "R11 high-half ignored", 32'(rirr_o[0]), 32'h1);
        win_low = 1'b1; win_idx = 8'd20;
        tick();
        chk(rirr_o[0], "R11 out-of-range ignored", 32'(rirr_o[0]), 32'h1);
        win_idx = 0;
        tick();
        win_wr = 1'b0;
        chk(!rirr_o[0] && dlv_valid && dlv_idx == 0, "R11 low-half clears", 32'({rirr_o[0], dlv_valid}), 32'h1);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) if ($urandom_range(0, 5) == 0) pin_in[i] = ~pin_in[i];
            if ($urandom_range(0, 40) == 0) begin
                cfg_pol  = N'($urandom);
                cfg_trig = N'($urandom);
                cfg_mask = N'($urandom) & N'($urandom);
                for (int i = 0; i < N; i++) cfg_vec[i*VW +: VW] = VW'($urandom_range(0, 5));
            end
            eoi_valid = ($urandom_range(0, 5) == 0);
            eoi_vec   = VW'($urandom_range(0, 7));
            win_wr    = ($urandom_range(0, 8) == 0);
            win_low   = 1'($urandom);
            win_idx   = WW'($urandom_range(0, 11));
            dlv_ready = ($urandom_range(0, 2) != 0);
            tick();
        end
        finish_run();
    end
endmodule